// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks which physical page frame to give up when memory is full. It keeps one reference flag for each frame and a circular hand that points at one frame. The translation path reports every frame it uses on a use port, and that port sets the frame's flag. Software can also zero every flag at once.

When a victim is requested, the block walks the frames from the hand, one frame per clock. A frame whose flag is set gets a second chance: its flag is cleared and the hand moves on, wrapping past the last frame back to frame 0. The first frame found with a clear flag is reported as the victim. The hand stays on that frame, and its position carries over to the next request. If every flag was set, the walk clears them all during one full lap and returns the frame where it started. Only the frame index is reported.

Top module: `clock_victim_sel`

## Requirements
- R1: After synchronous reset, every reference flag is 0, the hand points at frame 0, and both `busy` and `victim_valid` are 0.
- R2: A cycle with `use_valid` high sets the flag of frame `use_idx` to 1 at that clock edge.
- R3: A cycle with `clear_all` high zeroes every flag. If a use arrives in the same cycle, the used frame's flag still ends at 1.
- R4: `req` is accepted only while `busy` is 0. In the cycle after an accepted `req`, `busy` is 1. A `req` raised while `busy` is 1 is ignored and does not start another search.
- R5: While searching, the block examines the frame under the hand once per cycle. If that flag is 1, the flag is cleared and the hand advances by one modulo the frame count.
- R6: The first examined frame whose flag is 0 is reported. `victim_valid` is a one-cycle pulse and `victim_idx` carries the frame. With k set flags skipped, the pulse appears k+1 cycles after the cycle following the accepted `req`, and `busy` then returns to 0.
- R7: If every flag is 1 when a search starts, the search takes one full lap, leaves every flag at 0, and returns the starting frame.
- R8: The hand holds its position between searches. It stays on the last victim, so the next search first examines that frame.
- R9: If a use names the frame under the hand in the same cycle that the search would clear it, the use wins. The flag stays 1 and the frame is still skipped.
- R10: After frame NFRAMES-1 the hand wraps to frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_valid | input | 1 | A translation for frame `use_idx` was used |
| use_idx | input | IDXW | Frame being used |
| clear_all | input | 1 | Zero every reference flag |
| req | input | 1 | Request a victim frame |
| busy | output | 1 | A search is in progress |
| victim_valid | output | 1 | One-cycle pulse: `victim_idx` is valid |
| victim_idx | output | IDXW | Chosen victim frame |

## Verification
Two events can land in the same cycle: a use that sets a frame's flag, and the search clearing that frame's flag as the hand passes it. A second such pair is a use and `clear_all`. The bench provokes the first by driving a use of the frame under the hand on the first examination cycle. It provokes the second by pulsing a use together with `clear_all`. In both cases the surviving flag is judged only through later searches, by comparing each victim index and search latency with a bench-side model of the flags and the hand. An exhaustive sweep of every flag pattern on a four-frame configuration, run from the hand positions the sweep itself leaves behind, covers the skip, wrap and full-lap cases.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_SCAN = 1'b1
  } sweep_st_t;
endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [IDXW-1:0]    set_idx,
  input  logic               clr_en,
  input  logic [IDXW-1:0]    clr_idx,
  input  logic               clr_all,
  output logic [NFRAMES-1:0] bits
);
  // One flag per frame; a set from the use port always beats any clear.
  for (genvar i = 0; i < NFRAMES; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        bits[i] <= 1'b0;
      else if (set_en && set_idx == IDXW'(i))
        bits[i] <= 1'b1;
      else if (clr_all || (clr_en && clr_idx == IDXW'(i)))
        bits[i] <= 1'b0;
    end
  end

  AST_USE_SETS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> bits[$past(set_idx)]); // R2

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !set_en) |=> (bits == '0)); // R3
endmodule

// File: rtl/clock_hand.sv
module clock_hand
  import cvs_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            cur_ref,
  output logic [IDXW-1:0] hand,
  output logic            clr_en,
  output logic            busy,
  output logic            victim_valid,
  output logic [IDXW-1:0] victim_idx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NFRAMES - 1);

  sweep_st_t       state;
  logic [IDXW-1:0] hand_nxt;

  assign hand_nxt = (hand == LAST) ? '0 : hand + 1'b1;
  assign clr_en   = (state == SWEEP_SCAN) && cur_ref;
  assign busy     = (state == SWEEP_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SWEEP_IDLE;
      hand         <= '0;
      victim_valid <= 1'b0;
      victim_idx   <= '0;
    end else begin
      victim_valid <= 1'b0;
      case (state)
        SWEEP_IDLE: if (req) state <= SWEEP_SCAN;
        SWEEP_SCAN: begin
          if (cur_ref) begin
            hand <= hand_nxt;
          end else begin
            victim_valid <= 1'b1;
            victim_idx   <= hand;
            state        <= SWEEP_IDLE;
          end
        end
        default: state <= SWEEP_IDLE;
      endcase
    end
  end

  AST_HAND_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_ref) |=> (32'(hand) == (32'($past(hand)) + 1) % NFRAMES)); // R5

  AST_HAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(hand)); // R8

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    victim_valid |=> !victim_valid); // R6

  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> !busy); // R6
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 8,
  parameter int IDXW    = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            use_valid,
  input  logic [IDXW-1:0] use_idx,
  input  logic            clear_all,
  input  logic            req,
  output logic            busy,
  output logic            victim_valid,
  output logic [IDXW-1:0] victim_idx
);
  logic [NFRAMES-1:0] ref_bits;
  logic [IDXW-1:0]    hand;
  logic               clr_en;
  logic               cur_ref;
  logic [NFRAMES-1:0] vic_oh;

  assign cur_ref = ref_bits[hand];

  ref_bit_array #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_en  (use_valid),
    .set_idx (use_idx),
    .clr_en  (clr_en),
    .clr_idx (hand),
    .clr_all (clear_all),
    .bits    (ref_bits)
  );

  clock_hand #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_hand (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .cur_ref      (cur_ref),
    .hand         (hand),
    .clr_en       (clr_en),
    .busy         (busy),
    .victim_valid (victim_valid),
    .victim_idx   (victim_idx)
  );

  assign vic_oh = {{(NFRAMES-1){1'b0}}, 1'b1} << victim_idx;

  AST_VICTIM_UNREF: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> (($past(ref_bits) & vic_oh) == '0)); // R6

  AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_ref && !(use_valid && use_idx == hand)) |=> !ref_bits[$past(hand)]); // R5

  AST_USE_WINS: assert property (@(posedge clk) disable iff (rst)
    (busy && use_valid && use_idx == hand) |=> ref_bits[$past(hand)]); // R9
endmodule

// File: tb/sim_clock_victim_sel.sv
module sim_clock_victim_sel;
  localparam int N = 4;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic use_valid = 1'b0;
  logic [W-1:0] use_idx = '0;
  logic clear_all = 1'b0;
  logic req = 1'b0;
  logic busy, victim_valid;
  logic [W-1:0] victim_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit m_ref [N];
  int m_hand = 0;

  always #5 clk = ~clk;

  clock_victim_sel #(.NFRAMES(N)) u0 (
    .clk(clk), .rst(rst), .use_valid(use_valid), .use_idx(use_idx),
    .clear_all(clear_all), .req(req), .busy(busy),
    .victim_valid(victim_valid), .victim_idx(victim_idx)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic use_frame(input int f);
    @(negedge clk); use_valid = 1'b1; use_idx = W'(f);
    @(negedge clk); use_valid = 1'b0;
    m_ref[f] = 1'b1;
  endtask

  // R3: clear pulse, optionally with a use in the same cycle
  task automatic clear_pulse(input bit wu, input int uf);
    @(negedge clk); clear_all = 1'b1; use_valid = wu; use_idx = W'(uf);
    @(negedge clk); clear_all = 1'b0; use_valid = 1'b0;
    for (int i = 0; i < N; i++) m_ref[i] = 1'b0;
    if (wu) m_ref[uf] = 1'b1;
  endtask

  task automatic run_search(input bit wu, input int uf, input bit extra_req, input string tag);
    int k = 0;
    int exp_v = -1;
    int n = 0;
    while (exp_v < 0) begin
      bit b = m_ref[m_hand];
      if (b) begin
        m_ref[m_hand] = 1'b0;
        m_hand = (m_hand + 1) % N;
      end else begin
        exp_v = m_hand;
      end
      if (k == 0 && wu) m_ref[uf] = 1'b1;
      if (b) k++;
    end
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check(busy === 1'b1, "R4 busy after req", int'(busy), 1);
    if (wu) begin use_valid = 1'b1; use_idx = W'(uf); end
    do begin
      @(negedge clk);
      n++;
      use_valid = 1'b0;
      req = (extra_req && n == 1);
    end while (!victim_valid && n < 2*N + 4);
    req = 1'b0;
    check(n == k + 1, {tag, " latency"}, n, k + 1);
    check(int'(victim_idx) == exp_v, {tag, " victim"}, int'(victim_idx), exp_v);
    if (extra_req) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        check(!busy && !victim_valid, "R4 req while busy ignored", int'(busy), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0, "R1 busy reset", int'(busy), 0);
    check(victim_valid === 1'b0, "R1 victim_valid reset", int'(victim_valid), 0);
    // R1: no flags set, hand at 0 -> victim 0 immediately
    run_search(1'b0, 0, 1'b0, "R1 reset search");

    // R2 R5 R6 R10: exhaustive flag patterns from the hand left by each search
    for (int p = 0; p < (1 << N); p++) begin
      clear_pulse(1'b0, 0);
      for (int f = 0; f < N; f++) if (p[f]) use_frame(f);
      run_search(1'b0, 0, 1'b0, "R6 R5 R10 sweep");
    end

    // R7 with R4: all flags set, full lap, extra req during search ignored
    for (int f = 0; f < N; f++) use_frame(f);
    run_search(1'b0, 0, 1'b1, "R7 full lap");
    // R7: all cleared by the lap, so the next search returns the hand at once
    run_search(1'b0, 0, 1'b0, "R7 flags cleared");

    // R8: reuse of the victim, next search starts there and skips it
    use_frame(m_hand);
    run_search(1'b0, 0, 1'b0, "R8 hand persists");

    // R9: use of frame under the hand while the search would clear it
    clear_pulse(1'b0, 0);
    use_frame(m_hand);
    run_search(1'b1, m_hand, 1'b0, "R9 use wins");
    for (int f = 0; f < N; f++) use_frame(f);
    run_search(1'b0, 0, 1'b0, "R9 flag kept");

    // R3: clear_all with a simultaneous use
    for (int f = 0; f < N; f++) use_frame(f);
    clear_pulse(1'b1, m_hand);
    run_search(1'b0, 0, 1'b0, "R3 clear with use");
    for (int f = 0; f < N; f++) use_frame(f);
    clear_pulse(1'b1, (m_hand + 2) % N);
    run_search(1'b0, 0, 1'b0, "R3 clear with use other");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule